// File: doc/BRIEF.md
# Configuration Strap Capture Unit

This unit reads a handful of board-level configuration straps and turns them into stable settings for the rest of the device. Two of the straps are three-level address pins, each delivered to the unit as a 2-bit code already resolved into low, middle or high. The others are single-bit: the equalizer select, the spread-spectrum enable and the data-rate select. The unit turns the address pins into one of nine device-address indices, converts the equalizer select into a 4-bit tuning word, and passes the spread-spectrum and rate selects through as held flags.

The straps are sampled only at two moments: on the first clock edge after reset is released, and on the first clock edge after the active-low power-down input returns high. Between those moments the outputs do not move, whatever the strap pins do. Each capture is marked by a one-cycle `cfg_valid` pulse that arrives together with the new values. A small state machine with three states steps through this. `ARMED` is entered by reset. `RUN` holds the settings. `SLEEP` covers power-down. The transitions are `ARMED->RUN` (capture, power-down high), `ARMED->SLEEP` (power-down low), `RUN->SLEEP` (power-down falls), `SLEEP->RUN` (capture on wake), and the self-loops `RUN->RUN` and `SLEEP->SLEEP`.

Top module: `pin_strap_latch`

## Requirements
- R1: The address index equals 3*L1 + L0. L0 is the level of the strap pin at `addr_straps[1:0]` and L1 the level of the pin at `addr_straps[3:2]`. The codes are 2'b00 = 0 (low), 2'b01 = 1 (mid) and 2'b10 = 2 (high). The index is always in the range 0 to 8.
- R2: The reserved code 2'b11 on any address pin is read as mid (level 1).
- R3: `eq_sel` low at capture gives `eq_tune` = 4'b1001. `eq_sel` high at capture gives 4'b0100.
- R4: `ss_enable` equals the value `ss_strap` had on the capture edge (1 = spreading on).
- R5: `low_rate` equals the value `rate_strap` had on the capture edge (1 = low clock range, 0 = high range).
- R6: When `rst_n` is released with `pwdn_n` high, the straps are captured on the first clock edge. `cfg_valid` is high for the cycle after that edge, and the new outputs are visible in that same cycle.
- R7: On the first clock edge that sees `pwdn_n` high after it was low, the straps are captured again and `cfg_valid` pulses.
- R8: While `pwdn_n` is low, the outputs hold their last values, strap changes are ignored, and `cfg_valid` stays low.
- R9: While running (power-down high, no capture edge), strap changes have no effect on any output.
- R10: During reset, `dev_addr`, `eq_tune`, `ss_enable`, `low_rate` and `cfg_valid` are all zero.
- R11: `cfg_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn_n | input | 1 | Active-low power-down |
| addr_straps | input | 4 | Two pre-decoded 2-bit tri-level address codes, pin 0 in bits [1:0] |
| eq_sel | input | 1 | Equalizer select strap |
| ss_strap | input | 1 | Spread-spectrum enable strap |
| rate_strap | input | 1 | Data-rate select strap |
| dev_addr | output | 4 | Held device-address index, 0 to 8 |
| eq_tune | output | 4 | Held equalizer tuning word |
| ss_enable | output | 1 | Held spread-spectrum enable |
| low_rate | output | 1 | Held low-rate flag |
| cfg_valid | output | 1 | One-cycle pulse marking a capture |

## Verification
The assertions assume that `rst_n` is low from time zero. They also assume that the straps and `pwdn_n` change only between clock edges, so the value `$past` returns on a capture edge is the value that was actually latched. The bench meets both assumptions. It holds reset from the first instant and drives every input on the falling clock edge. It then reads the outputs one falling edge after the rising edge that should have captured. It moves the strap pins only while power-down is held, or in running stretches where the claim under test is that nothing changes.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        ST_ARMED = 2'b00,
        ST_RUN   = 2'b01,
        ST_SLEEP = 2'b10
    } strap_state_t;

    // Map a pre-decoded tri-level code to its level; reserved 2'b11 reads as mid.
    function automatic logic [1:0] tri_level(input logic [1:0] code);
        unique case (code)
            2'b00:   tri_level = 2'd0;
            2'b10:   tri_level = 2'd2;
            default: tri_level = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/tri_level_decode.sv
module tri_level_decode (
    input  logic [1:0] code,
    output logic [1:0] level
);
    import strap_pkg::*;

    always_comb begin
        level = tri_level(code);
    end
endmodule

// File: rtl/strap_fsm.sv
module strap_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pwdn_n,
    output logic capture_en
);
    import strap_pkg::*;

    strap_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: state_d = pwdn_n ? ST_RUN : ST_SLEEP;
            ST_RUN:   state_d = pwdn_n ? ST_RUN : ST_SLEEP;
            ST_SLEEP: state_d = pwdn_n ? ST_RUN : ST_SLEEP;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        capture_en = 1'b0;
        unique case (state_q)
            ST_ARMED: capture_en = pwdn_n;
            ST_SLEEP: capture_en = pwdn_n;
            ST_RUN:   capture_en = 1'b0;
            default:  capture_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/strap_hold_regs.sv
module strap_hold_regs #(
    parameter int ADDR_W = 4,
    parameter int TUNE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [TUNE_W-1:0] tune_d,
    input  logic              ss_d,
    input  logic              rate_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic [TUNE_W-1:0] tune_q,
    output logic              ss_q,
    output logic              rate_q,
    output logic              valid_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            tune_q  <= '0;
            ss_q    <= 1'b0;
            rate_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= capture_en;
            if (capture_en) begin
                addr_q <= addr_d;
                tune_q <= tune_d;
                ss_q   <= ss_d;
                rate_q <= rate_d;
            end
        end
    end
endmodule

// File: rtl/pin_strap_latch.sv
module pin_strap_latch #(
    parameter int              ADDR_PINS  = 2,
    parameter int              TUNE_W     = 4,
    parameter logic [TUNE_W-1:0] EQ_TUNE_LO = 4'b1001,
    parameter logic [TUNE_W-1:0] EQ_TUNE_HI = 4'b0100,
    localparam int             ADDR_COUNT = 3 ** ADDR_PINS,
    localparam int             ADDR_W     = $clog2(ADDR_COUNT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwdn_n,
    input  logic [2*ADDR_PINS-1:0] addr_straps,
    input  logic                   eq_sel,
    input  logic                   ss_strap,
    input  logic                   rate_strap,
    output logic [ADDR_W-1:0]      dev_addr,
    output logic [TUNE_W-1:0]      eq_tune,
    output logic                   ss_enable,
    output logic                   low_rate,
    output logic                   cfg_valid
);
    logic [1:0]        pin_level [ADDR_PINS];
    logic [ADDR_W-1:0] addr_next;
    logic [TUNE_W-1:0] tune_next;
    logic              capture_en;

    for (genvar p = 0; p < ADDR_PINS; p++) begin : g_pin
        tri_level_decode u_dec (
            .code  (addr_straps[2*p +: 2]),
            .level (pin_level[p])
        );
    end

    // Base-3 weighting: pin p contributes level * 3^p.
    always_comb begin
        int acc;
        int weight;
        acc    = 0;
        weight = 1;
        for (int p = 0; p < ADDR_PINS; p++) begin
            acc    = acc + int'(pin_level[p]) * weight;
            weight = weight * 3;
        end
        addr_next = ADDR_W'(acc);
    end

    always_comb begin
        tune_next = eq_sel ? EQ_TUNE_HI : EQ_TUNE_LO;
    end

    strap_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwdn_n     (pwdn_n),
        .capture_en (capture_en)
    );

    strap_hold_regs #(
        .ADDR_W (ADDR_W),
        .TUNE_W (TUNE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .addr_d     (addr_next),
        .tune_d     (tune_next),
        .ss_d       (ss_strap),
        .rate_d     (rate_strap),
        .addr_q     (dev_addr),
        .tune_q     (eq_tune),
        .ss_q       (ss_enable),
        .rate_q     (low_rate),
        .valid_q    (cfg_valid)
    );
endmodule

// File: rtl/pin_strap_latch_chk.sv
module pin_strap_latch_chk #(
    parameter int              ADDR_PINS  = 2,
    parameter int              TUNE_W     = 4,
    parameter logic [TUNE_W-1:0] EQ_TUNE_LO = 4'b1001,
    parameter logic [TUNE_W-1:0] EQ_TUNE_HI = 4'b0100,
    localparam int             ADDR_COUNT = 3 ** ADDR_PINS,
    localparam int             ADDR_W     = $clog2(ADDR_COUNT)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwdn_n,
    input logic [2*ADDR_PINS-1:0] addr_straps,
    input logic                   eq_sel,
    input logic                   ss_strap,
    input logic                   rate_strap,
    input logic [ADDR_W-1:0]      dev_addr,
    input logic [TUNE_W-1:0]      eq_tune,
    input logic                   ss_enable,
    input logic                   low_rate,
    input logic                   cfg_valid
);
    p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dev_addr) < ADDR_COUNT);

    p_addr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && $past(addr_straps) == '0) |-> dev_addr == '0);

    p_eq_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> eq_tune == ($past(eq_sel) ? EQ_TUNE_HI : EQ_TUNE_LO));

    p_ss_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ss_enable == $past(ss_strap));

    p_rate_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> low_rate == $past(rate_strap));

    p_wake_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwdn_n) |=> cfg_valid);

    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwdn_n |=> !cfg_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> $stable({dev_addr, eq_tune, ss_enable, low_rate}));

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);
endmodule

bind pin_strap_latch pin_strap_latch_chk #(
    .ADDR_PINS  (ADDR_PINS),
    .TUNE_W     (TUNE_W),
    .EQ_TUNE_LO (EQ_TUNE_LO),
    .EQ_TUNE_HI (EQ_TUNE_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwdn_n      (pwdn_n),
    .addr_straps (addr_straps),
    .eq_sel      (eq_sel),
    .ss_strap    (ss_strap),
    .rate_strap  (rate_strap),
    .dev_addr    (dev_addr),
    .eq_tune     (eq_tune),
    .ss_enable   (ss_enable),
    .low_rate    (low_rate),
    .cfg_valid   (cfg_valid)
);

// File: tb/tb_pin_strap_latch.sv
`timescale 1ns/1ps
module tb_pin_strap_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwdn_n = 1'b1;
    logic [3:0] addr_straps = 4'b0000;
    logic       eq_sel = 1'b0;
    logic       ss_strap = 1'b0;
    logic       rate_strap = 1'b0;
    logic [3:0] dev_addr;
    logic [3:0] eq_tune;
    logic       ss_enable;
    logic       low_rate;
    logic       cfg_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pin_strap_latch dut (
        .clk(clk), .rst_n(rst_n), .pwdn_n(pwdn_n), .addr_straps(addr_straps),
        .eq_sel(eq_sel), .ss_strap(ss_strap), .rate_strap(rate_strap),
        .dev_addr(dev_addr), .eq_tune(eq_tune), .ss_enable(ss_enable),
        .low_rate(low_rate), .cfg_valid(cfg_valid)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int lvl(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
    endfunction

    function automatic int exp_addr(input logic [3:0] s);
        return 3 * lvl(s[3:2]) + lvl(s[1:0]);
    endfunction

    // Power down, set straps, wake; returns at the falling edge after the capture edge.
    task automatic wake_with(input logic [3:0] a, input logic e, input logic s, input logic r);
        @(negedge clk); pwdn_n = 1'b0;
        @(negedge clk); addr_straps = a; eq_sel = e; ss_strap = s; rate_strap = r;
        @(negedge clk); pwdn_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        addr_straps = 4'b1010; eq_sel = 1'b1; ss_strap = 1'b1; rate_strap = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 dev_addr", dev_addr, 0);
        check("R10 eq_tune", eq_tune, 0);
        check("R10 ss_enable", ss_enable, 0);
        check("R10 low_rate", low_rate, 0);
        check("R10 cfg_valid", cfg_valid, 0);
    endtask

    task automatic t_power_up_capture;
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 cfg_valid", cfg_valid, 1);
        check("R6 dev_addr", dev_addr, 8);
        check("R6 eq_tune", eq_tune, 4'b0100);
        check("R6 ss_enable", ss_enable, 1);
        check("R6 low_rate", low_rate, 1);
        @(negedge clk);
        check("R11 cfg_valid drops", cfg_valid, 0);
    endtask

    task automatic t_address_sweep;
        for (int v = 0; v < 16; v++) begin
            wake_with(4'(v), 1'b0, 1'b0, 1'b0);
            check("R7 cfg_valid on wake", cfg_valid, 1);
            if (v[1:0] == 2'b11 || v[3:2] == 2'b11)
                check("R2 reserved as mid", dev_addr, exp_addr(4'(v)));
            else
                check("R1 address index", dev_addr, exp_addr(4'(v)));
        end
    endtask

    task automatic t_eq_ss_rate;
        for (int v = 0; v < 8; v++) begin
            wake_with(4'b0101, v[0], v[1], v[2]);
            check("R3 eq_tune", eq_tune, v[0] ? 4'b0100 : 4'b1001);
            check("R4 ss_enable", ss_enable, v[1]);
            check("R5 low_rate", low_rate, v[2]);
        end
    endtask

    task automatic t_ignore_in_powerdown;
        wake_with(4'b0001, 1'b0, 1'b1, 1'b0);
        @(negedge clk); pwdn_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr_straps = 4'(k + 8); eq_sel = ~eq_sel; ss_strap = ~ss_strap; rate_strap = ~rate_strap;
            check("R8 cfg_valid low in sleep", cfg_valid, 0);
            check("R8 dev_addr held", dev_addr, 1);
            check("R8 eq_tune held", eq_tune, 4'b1001);
            check("R8 ss_enable held", ss_enable, 1);
        end
        @(negedge clk); addr_straps = 4'b0100; eq_sel = 1'b1; ss_strap = 1'b0; rate_strap = 1'b1;
        pwdn_n = 1'b1;
        @(negedge clk);
        check("R7 wake cfg_valid", cfg_valid, 1);
        check("R7 wake dev_addr", dev_addr, 3);
        check("R7 wake low_rate", low_rate, 1);
    endtask

    task automatic t_ignore_while_running;
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            addr_straps = 4'(k * 3); eq_sel = k[0]; ss_strap = ~k[0]; rate_strap = k[1];
            @(negedge clk);
            check("R9 cfg_valid", cfg_valid, 0);
            check("R9 dev_addr", dev_addr, 3);
            check("R9 eq_tune", eq_tune, 4'b0100);
            check("R9 ss_enable", ss_enable, 0);
            check("R9 low_rate", low_rate, 1);
        end
    endtask

    task automatic t_reset_into_powerdown;
        @(negedge clk); rst_n = 1'b0; pwdn_n = 1'b0; addr_straps = 4'b0010;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R8 no capture while held down", cfg_valid, 0);
            check("R8 dev_addr at reset value", dev_addr, 0);
        end
        pwdn_n = 1'b1;
        @(negedge clk);
        check("R7 first wake cfg_valid", cfg_valid, 1);
        check("R7 first wake dev_addr", dev_addr, 2);
        @(negedge clk);
        check("R11 single pulse", cfg_valid, 0);
    endtask

    initial begin
        t_reset_state();
        t_power_up_capture();
        t_address_sweep();
        t_eq_ss_rate();
        t_ignore_in_powerdown();
        t_ignore_while_running();
        t_reset_into_powerdown();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule